// File: doc/BRIEF.md
# Prioritised Core Event Controller

This block sits between a set of core event lines and the instruction sequencer. Each line is watched for a rising edge; a detected edge records the event in a latch register. A mask register picks which latched events may be serviced, and a global enable gates the upper, general-purpose part of the event range. Of the events that are latched, unmasked and enabled, the one with the lowest index is offered to the core as a request with its vector. It is offered only when it outranks every level that is already active.

When the core accepts the request, the event leaves the latch and enters the pending register in the same clock update. The pending register therefore holds one bit per level that is active or nested. A return strobe from the core retires the innermost active level, which is the lowest set pending bit, so the level it interrupted becomes current again. Software reaches the three registers through a small read/write port that works only in supervisor mode. Through that port it can cancel latched events that are masked.

Top module: `core_evt_ctl`

## Requirements
- R1: After reset the latch, mask and pending registers read as zero, the global enable is set, and `core_req` is low.
- R2: A rising edge on `evt_in[i]` sets latch bit i on the second rising clock edge at which the input is sampled high. An input that stays high does not set the bit again once it has been cleared.
- R3: When `core_ack` is high while `core_req` is high and `core_ret` is low, pending bit `core_vec` is set and latch bit `core_vec` is cleared in the same update. `core_ack` while `core_req` is low has no effect.
- R4: A supervisor write to register select 0 (latch) clears each latch bit i whose write-data bit is 0 and whose mask bit is 0. All other latch bits keep their value. An edge detected in the same cycle still sets its bit.
- R5: Mask bit i at 1 allows event i to be requested. At 0 the event is not requested but is still latched. Register select 1 reads and writes the mask.
- R6: `core_req` is high exactly when some event is latched, unmasked and enabled, and the lowest such index is below the lowest set pending bit (or no pending bit is set). `core_vec` gives that index.
- R7: `core_ret` clears the lowest set pending bit. When `core_ret` and `core_ack` are high in the same cycle, the accept is ignored.
- R8: `glb_clr` clears the global enable and `glb_set` sets it; `glb_clr` wins when both are high. While the enable is clear, events with index at or above `GP_FIRST` are not requested, but they still latch.
- R9: Register select 2 reads the pending register and ignores writes; select 3 reads zero. With `sup_mode` low, writes are ignored and `reg_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | NUM_EVT | Event lines, one per level |
| sup_mode | input | 1 | Supervisor-mode qualifier for register access |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 latch, 1 mask, 2 pending, 3 none |
| reg_wdata | input | NUM_EVT | Write data |
| reg_rdata | output | NUM_EVT | Read data for the selected register |
| glb_set | input | 1 | Enable general-purpose events |
| glb_clr | input | 1 | Disable general-purpose events |
| core_req | output | 1 | Event request to the core |
| core_vec | output | $clog2(NUM_EVT) | Index of the requested event |
| core_ack | input | 1 | Core accepts the current request |
| core_ret | input | 1 | Core returns from the innermost event |

## Verification
The bench builds the block with its defaults: NUM_EVT of 16 and GP_FIRST of 7. With these values, events on both sides of the global-enable boundary are reachable, and so is nesting several levels deep across all sixteen pending bits. A directed sequence first walks through edge timing, acceptance, nested return, accept and return in the same cycle, and masked cancellation. After that, a long stretch of random stimulus is compared on every cycle against a behavioural model. This stretch reaches edges that coincide with latch writes and acceptances that occur while the global enable is clear.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        SEL_LATCH = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_PEND  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/evt_edge.sv
module evt_edge #(
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [NUM_EVT-1:0] rise
);
    typedef struct packed {
        logic [NUM_EVT-1:0] smp;
        logic [NUM_EVT-1:0] hist;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.smp  = evt_in;
        st_d.hist = st_q.smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.smp & ~st_q.hist;

    // R2: an edge is reported for exactly one cycle
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/evt_ffs.sv
module evt_ffs #(
    parameter int NUM_EVT = 16,
    localparam int IDX_W  = $clog2(NUM_EVT)
) (
    input  logic [NUM_EVT-1:0] vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/evt_rdmux.sv
module evt_rdmux #(
    parameter int NUM_EVT = 16
) (
    input  logic               sup_mode,
    input  logic [1:0]         sel,
    input  logic [NUM_EVT-1:0] lat,
    input  logic [NUM_EVT-1:0] msk,
    input  logic [NUM_EVT-1:0] pnd,
    output logic [NUM_EVT-1:0] rdata
);
    import evt_pkg::*;

    always_comb begin
        rdata = '0;
        if (sup_mode) begin
            case (reg_sel_e'(sel))
                SEL_LATCH: rdata = lat;
                SEL_MASK:  rdata = msk;
                SEL_PEND:  rdata = pnd;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/core_evt_ctl.sv
module core_evt_ctl #(
    parameter int NUM_EVT  = 16,
    parameter int GP_FIRST = 7,
    localparam int IDX_W   = $clog2(NUM_EVT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               sup_mode,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [NUM_EVT-1:0] reg_wdata,
    output logic [NUM_EVT-1:0] reg_rdata,
    input  logic               glb_set,
    input  logic               glb_clr,
    output logic               core_req,
    output logic [IDX_W-1:0]   core_vec,
    input  logic               core_ack,
    input  logic               core_ret
);
    import evt_pkg::*;

    typedef struct packed {
        logic [NUM_EVT-1:0] lat;
        logic [NUM_EVT-1:0] msk;
        logic [NUM_EVT-1:0] pnd;
        logic               en;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [NUM_EVT-1:0] rise;
    logic [NUM_EVT-1:0] core_bits;
    logic [NUM_EVT-1:0] gate;
    logic [NUM_EVT-1:0] cand;
    logic               cand_found, pend_found;
    logic [IDX_W-1:0]   cand_idx, pend_idx;
    logic               wr_ok;

    evt_edge #(.NUM_EVT(NUM_EVT)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .rise   (rise)
    );

    // events below GP_FIRST ignore the global enable
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_core
        assign core_bits[g] = (g < GP_FIRST);
    end

    assign gate = st_q.en ? {NUM_EVT{1'b1}} : core_bits;
    assign cand = st_q.lat & st_q.msk & gate;

    evt_ffs #(.NUM_EVT(NUM_EVT)) u_cand (
        .vec   (cand),
        .found (cand_found),
        .idx   (cand_idx)
    );

    evt_ffs #(.NUM_EVT(NUM_EVT)) u_pend (
        .vec   (st_q.pnd),
        .found (pend_found),
        .idx   (pend_idx)
    );

    assign core_req = cand_found && (!pend_found || (cand_idx < pend_idx));
    assign core_vec = cand_idx;
    assign wr_ok    = reg_wr && sup_mode;

    evt_rdmux #(.NUM_EVT(NUM_EVT)) u_rd (
        .sup_mode (sup_mode),
        .sel      (reg_sel),
        .lat      (st_q.lat),
        .msk      (st_q.msk),
        .pnd      (st_q.pnd),
        .rdata    (reg_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ok && reg_sel_e'(reg_sel) == SEL_LATCH)
            st_d.lat = st_q.lat & (reg_wdata | st_q.msk);
        if (wr_ok && reg_sel_e'(reg_sel) == SEL_MASK)
            st_d.msk = reg_wdata;
        if (core_ret) begin
            if (pend_found) st_d.pnd[pend_idx] = 1'b0;
        end else if (core_ack && core_req) begin
            st_d.pnd[cand_idx] = 1'b1;
            st_d.lat[cand_idx] = 1'b0;
        end
        st_d.lat = st_d.lat | rise;
        if (glb_clr)      st_d.en = 1'b0;
        else if (glb_set) st_d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.en  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: accepted event becomes pending
    p_ack_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && core_req && !core_ret) |=> st_q.pnd[$past(core_vec)]);

    // R3: accepted event leaves the latch unless a fresh edge arrived
    p_ack_unlatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && core_req && !core_ret)
            |=> (!st_q.lat[$past(core_vec)] || $past(rise[core_vec])));

    // R5: only latched, unmasked events are offered
    p_req_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (st_q.lat[core_vec] && st_q.msk[core_vec]));

    // R6: request outranks every active level
    p_req_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> ((st_q.pnd & ((NUM_EVT'(1) << core_vec) << 1) - NUM_EVT'(1)) == '0
                      || (st_q.pnd & ~(((NUM_EVT'(1) << core_vec) << 1) - NUM_EVT'(1))) == st_q.pnd
                         && (st_q.pnd & (((NUM_EVT'(1) << core_vec) << 1) - NUM_EVT'(1))) == '0));

    // R7: a return retires exactly one active level
    p_ret_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ret && st_q.pnd != '0) |=> ($countones(st_q.pnd) == $countones($past(st_q.pnd)) - 1));

    // R8: with the global enable clear only low events are offered
    p_glb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !st_q.en) |-> (int'(core_vec) < GP_FIRST));

    // R9: user-mode writes leave the mask alone
    p_user_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !sup_mode) |=> (st_q.msk == $past(st_q.msk)));

endmodule

// File: tb/sim_core_evt_ctl.sv
module sim_core_evt_ctl;
    localparam int N  = 16;
    localparam int GP = 7;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_in = '0;
    logic          sup_mode = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic          glb_set = 1'b0, glb_clr = 1'b0;
    logic          core_req;
    logic [IW-1:0] core_vec;
    logic          core_ack = 1'b0, core_ret = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    core_evt_ctl #(.NUM_EVT(N), .GP_FIRST(GP)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sup_mode(sup_mode),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .glb_set(glb_set), .glb_clr(glb_clr),
        .core_req(core_req), .core_vec(core_vec),
        .core_ack(core_ack), .core_ret(core_ret)
    );

    // behavioural reference model
    bit [N-1:0] m_smp, m_hist, m_lat, m_msk, m_pnd;
    bit         m_en = 1'b1;

    function automatic int low_set(input bit [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return N;
    endfunction

    function automatic int m_cand();
        bit [N-1:0] c;
        for (int i = 0; i < N; i++) c[i] = m_lat[i] & m_msk[i] & (m_en | (i < GP));
        return low_set(c);
    endfunction

    function automatic bit m_req();
        int c = m_cand();
        return (c < N) && (c < low_set(m_pnd));
    endfunction

    function automatic bit [N-1:0] m_rd();
        if (!sup_mode) return '0;
        case (reg_sel)
            2'd0: return m_lat;
            2'd1: return m_msk;
            2'd2: return m_pnd;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_smp = '0; m_hist = '0; m_lat = '0; m_msk = '0; m_pnd = '0; m_en = 1'b1;
        end else begin
            bit [N-1:0] nl, nm, np, edg;
            bit req;
            int c, p;
            edg = m_smp & ~m_hist;
            req = m_req();
            c   = m_cand();
            p   = low_set(m_pnd);
            nl = m_lat; nm = m_msk; np = m_pnd;
            if (reg_wr && sup_mode && reg_sel == 2'd0)
                for (int i = 0; i < N; i++) if (!m_msk[i] && !reg_wdata[i]) nl[i] = 1'b0;
            if (reg_wr && sup_mode && reg_sel == 2'd1) nm = reg_wdata;
            if (core_ret) begin
                if (p < N) np[p] = 1'b0;
            end else if (core_ack && req) begin
                np[c] = 1'b1;
                nl[c] = 1'b0;
            end
            nl = nl | edg;
            if (glb_clr) m_en = 1'b0;
            else if (glb_set) m_en = 1'b1;
            m_lat = nl; m_msk = nm; m_pnd = np;
            m_hist = m_smp; m_smp = evt_in;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R6 request", 32'(core_req), 32'(m_req()));
            if (m_req()) chk("R6 vector", 32'(core_vec), 32'(m_cand()));
            chk((reg_sel == 2'd0) ? "R2/R4 latch read" :
                (reg_sel == 2'd1) ? "R5 mask read" : "R9 pending/none read",
                32'(reg_rdata), 32'(m_rd()));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [N-1:0] d, input logic sup);
        reg_sel = sel; reg_wdata = d; sup_mode = sup; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; sup_mode = 1'b1;
    endtask

    task automatic rd(input logic [1:0] sel, input logic sup, output logic [N-1:0] v);
        reg_sel = sel; sup_mode = sup;
        #1;
        v = reg_rdata;
        sup_mode = 1'b1;
    endtask

    task automatic pulse_ack(); core_ack = 1'b1; tick(); core_ack = 1'b0; endtask
    task automatic pulse_ret(); core_ret = 1'b1; tick(); core_ret = 1'b0; endtask

    initial begin
        logic [N-1:0] v;
        logic [31:0]  lf;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        rd(2'd0, 1'b1, v); chk("R1 latch after reset", 32'(v), 32'h0);
        rd(2'd1, 1'b1, v); chk("R1 mask after reset", 32'(v), 32'h0);
        rd(2'd2, 1'b1, v); chk("R1 pending after reset", 32'(v), 32'h0);
        chk("R1 no request", 32'(core_req), 32'h0);

        wreg(2'd1, 16'hFFFF, 1'b1);
        rd(2'd1, 1'b1, v); chk("R5 mask written", 32'(v), 32'hFFFF);

        evt_in[5] = 1'b1;
        tick(); rd(2'd0, 1'b1, v); chk("R2 not yet latched", 32'(v), 32'h0);
        tick(); rd(2'd0, 1'b1, v); chk("R2 latched after two edges", 32'(v), 32'h0020);
        chk("R6 request for 5", 32'(core_req), 32'h1);
        chk("R6 vector 5", 32'(core_vec), 32'd5);

        pulse_ack();
        rd(2'd2, 1'b1, v); chk("R3 pending after accept", 32'(v), 32'h0020);
        rd(2'd0, 1'b1, v); chk("R3 latch cleared on accept", 32'(v), 32'h0);
        pulse_ack();
        rd(2'd2, 1'b1, v); chk("R3 accept without request ignored", 32'(v), 32'h0020);
        repeat (3) tick();
        rd(2'd0, 1'b1, v); chk("R2 held level not relatched", 32'(v), 32'h0);

        evt_in[9] = 1'b1; tick(); tick();
        rd(2'd0, 1'b1, v); chk("R6 lower event latched", 32'(v), 32'h0200);
        chk("R6 lower event not offered", 32'(core_req), 32'h0);
        evt_in[2] = 1'b1; tick(); tick();
        chk("R6 nesting request", 32'(core_req), 32'h1);
        chk("R6 nesting vector 2", 32'(core_vec), 32'd2);

        core_ack = 1'b1; core_ret = 1'b1; tick(); core_ack = 1'b0; core_ret = 1'b0;
        rd(2'd2, 1'b1, v); chk("R7 return wins over accept", 32'(v), 32'h0);
        rd(2'd0, 1'b1, v); chk("R7 latch kept when accept ignored", 32'(v), 32'h0204);

        pulse_ack();
        rd(2'd2, 1'b1, v); chk("R3 pending 2", 32'(v), 32'h0004);
        chk("R6 9 below active 2", 32'(core_req), 32'h0);
        pulse_ret();
        rd(2'd2, 1'b1, v); chk("R7 innermost retired", 32'(v), 32'h0);
        chk("R7 next level offered", 32'(core_vec), 32'd9);

        glb_clr = 1'b1; glb_set = 1'b1; tick(); glb_clr = 1'b0; glb_set = 1'b0;
        chk("R8 disable wins, 9 blocked", 32'(core_req), 32'h0);
        rd(2'd0, 1'b1, v); chk("R8 still latched", 32'(v), 32'h0200);
        glb_set = 1'b1; tick(); glb_set = 1'b0;
        chk("R8 re-enabled", 32'(core_req), 32'h1);

        wreg(2'd1, 16'hFDFF, 1'b1);
        chk("R5 masked not offered", 32'(core_req), 32'h0);
        wreg(2'd0, 16'h0000, 1'b0);
        rd(2'd0, 1'b1, v); chk("R9 user write ignored", 32'(v), 32'h0200);
        rd(2'd0, 1'b0, v); chk("R9 user read zero", 32'(v), 32'h0);
        wreg(2'd0, 16'h0000, 1'b1);
        rd(2'd0, 1'b1, v); chk("R4 masked latch cancelled", 32'(v), 32'h0);
        wreg(2'd2, 16'hFFFF, 1'b1);
        rd(2'd2, 1'b1, v); chk("R9 pending not writable", 32'(v), 32'h0);
        rd(2'd3, 1'b1, v); chk("R9 select 3 reads zero", 32'(v), 32'h0);

        // random phase, compared on every cycle
        lf = 32'h1ACE_B00C;
        for (int k = 0; k < 4000; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = lf ^ $urandom;
            if (lf[2:0] == 3'd0) evt_in[lf[6:3]] = ~evt_in[lf[6:3]];
            core_ack  = lf[8];
            core_ret  = (lf[12:9] == 4'd0);
            sup_mode  = (lf[14:13] != 2'd0);
            reg_wr    = (lf[17:15] == 3'd0);
            reg_sel   = lf[19:18];
            reg_wdata = lf[31:16] | (lf[20] ? 16'h0 : 16'hF0F0);
            glb_clr   = (lf[25:21] == 5'd0);
            glb_set   = (lf[25:21] == 5'd1);
            tick();
        end
        core_ack = 1'b0; core_ret = 1'b0; reg_wr = 1'b0; glb_clr = 1'b0; glb_set = 1'b0;
        tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule